// File: doc/BRIEF.md
# Windowed Outbound Address Translator

This block maps addresses issued by a processor onto the address space of an attached PCI bus. The incoming address is first reduced by discarding its top nibble. One bit of what remains tells whether the access falls inside a 128 MB aperture reserved for PCI or lands elsewhere on the system bus.

Inside the aperture, three bits pick one of eight 16 MB windows. Each window owns a 32-bit offset register that software may rewrite at any time. The block removes the window-select bits and adds the chosen offset to the 24-bit position within the window. The sum is the outbound PCI address.

Each request comes with a valid strobe. The answer appears one clock later on registered outputs, together with a flag that says whether the access targeted PCI. Traffic mastered by a PCI device does not pass through this block.

Top module: `xlat_outbound`

## Requirements
- R1: While reset is high and on the first cycle after it, out_vld, out_pci and out_addr are all zero. Window k's offset resets to 0x10000000 + k × 0x01000000, so that, right after reset, an aperture address translates to itself with bits 31:28 set to 0x1.
- R2: out_vld is high in the cycle after a cycle with in_vld high, and low in the cycle after a cycle with in_vld low.
- R3: out_pci is 1 when bit 27 of the accepted address is 0 (PCI aperture). It is 0 when that bit is 1.
- R4: For an aperture access, out_addr = offset[in_addr[26:24]] + in_addr[23:0], with the low field zero-extended. Bits 31:28 of the input have no effect.
- R5: For a non-aperture access, out_addr equals in_addr with bits 31:28 forced to zero. The window registers do not influence it.
- R6: A write (wr_en high, wr_idx, wr_data) replaces that window's offset. The new value is used by requests accepted in a later cycle. A request accepted in the same cycle as the write still sees the previous offset.
- R7: A write changes only the window named by wr_idx. The other seven offsets keep their values.
- R8: The offset addition is modulo 2^32. A carry out of bit 31 is dropped, and there is no error indication.
- R9: While in_vld is low, out_addr and out_pci keep the value of the last accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Window offset write strobe |
| wr_idx | input | 3 | Window number to write |
| wr_data | input | 32 | New offset value |
| in_vld | input | 1 | Request address valid |
| in_addr | input | 32 | Processor-side address |
| out_vld | output | 1 | Translated result valid |
| out_pci | output | 1 | 1 = access falls in PCI aperture |
| out_addr | output | 32 | Translated address |

## Verification
An offset write and a translation through the same window can occur in one clock. The bench drives both strobes in the same cycle, with the request aimed at the window being rewritten. It then expects the previous offset in the result. It repeats the request in the following cycle and expects the new offset. A write to a different window in the same cycle as a request is also checked, to confirm that the request's own window is left untouched.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int XL_ADDR_W  = 32;
    localparam int XL_SEG_W   = 24;
    localparam int XL_IDX_W   = 3;
    localparam logic [31:0] XL_RESET_BASE = 32'h1000_0000;

    typedef enum logic {
        RGN_PCI   = 1'b0,
        RGN_OTHER = 1'b1
    } region_e;

    // Offset loaded into window k at reset: base plus k segments.
    function automatic logic [XL_ADDR_W-1:0] win_reset_value(
        input logic [XL_ADDR_W-1:0] base,
        input int                   k,
        input int                   seg_w
    );
        logic [XL_ADDR_W-1:0] step;
        step = XL_ADDR_W'(k) << seg_w;
        return base + step;
    endfunction

endpackage

// File: rtl/xlat_win_regs.sv
module xlat_win_regs #(
    parameter int          ADDR_W     = 32,
    parameter int          SEG_W      = 24,
    parameter int          IDX_W      = 3,
    parameter logic [31:0] RESET_BASE = 32'h1000_0000,
    localparam int         NUM_WIN    = 1 << IDX_W
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  logic [IDX_W-1:0]                wr_idx,
    input  logic [ADDR_W-1:0]               wr_data,
    output logic [NUM_WIN-1:0][ADDR_W-1:0]  offs
);
    import xlat_pkg::*;

    for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
        logic [ADDR_W-1:0] ofs_q;
        logic              hit;

        assign hit = wr_en && (wr_idx == IDX_W'(k));

        always_ff @(posedge clk) begin
            if (rst) begin
                ofs_q <= ADDR_W'(win_reset_value(XL_ADDR_W'(RESET_BASE), k, SEG_W));
            end else if (hit) begin
                ofs_q <= wr_data;
            end
        end

        assign offs[k] = ofs_q;
    end

endmodule

// File: rtl/xlat_decode.sv
module xlat_decode #(
    parameter int  ADDR_W     = 32,
    parameter int  SEG_W      = 24,
    parameter int  IDX_W      = 3,
    localparam int REGION_BIT = SEG_W + IDX_W
) (
    input  logic [ADDR_W-1:0]  addr,
    output xlat_pkg::region_e  region,
    output logic [IDX_W-1:0]   win_idx,
    output logic [SEG_W-1:0]   seg_ofs,
    output logic [ADDR_W-1:0]  pass_addr
);
    import xlat_pkg::*;

    localparam logic [ADDR_W-1:0] KEEP_MASK =
        ADDR_W'((64'd1 << (REGION_BIT + 1)) - 64'd1);

    always_comb begin
        region    = addr[REGION_BIT] ? RGN_OTHER : RGN_PCI;
        win_idx   = addr[REGION_BIT-1:SEG_W];
        seg_ofs   = addr[SEG_W-1:0];
        pass_addr = addr & KEEP_MASK;
    end

endmodule

// File: rtl/xlat_add_stage.sv
module xlat_add_stage #(
    parameter int  ADDR_W  = 32,
    parameter int  SEG_W   = 24,
    parameter int  IDX_W   = 3,
    localparam int NUM_WIN = 1 << IDX_W
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            in_vld,
    input  xlat_pkg::region_e               region,
    input  logic [IDX_W-1:0]                win_idx,
    input  logic [SEG_W-1:0]                seg_ofs,
    input  logic [ADDR_W-1:0]               pass_addr,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0]  offs,
    output logic                            res_vld,
    output logic                            res_pci,
    output logic [ADDR_W-1:0]               res_addr
);
    import xlat_pkg::*;

    logic [ADDR_W-1:0] sel_ofs;
    logic [ADDR_W-1:0] sum;
    logic [ADDR_W-1:0] nxt_addr;

    always_comb begin
        sel_ofs  = offs[win_idx];
        sum      = sel_ofs + ADDR_W'(seg_ofs);
        nxt_addr = (region == RGN_PCI) ? sum : pass_addr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_vld  <= 1'b0;
            res_pci  <= 1'b0;
            res_addr <= '0;
        end else begin
            res_vld <= in_vld;
            if (in_vld) begin
                res_pci  <= (region == RGN_PCI);
                res_addr <= nxt_addr;
            end
        end
    end

endmodule

// File: rtl/xlat_outbound.sv
module xlat_outbound #(
    parameter int          ADDR_W     = 32,
    parameter int          SEG_W      = 24,
    parameter int          IDX_W      = 3,
    parameter logic [31:0] RESET_BASE = 32'h1000_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              in_vld,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              out_vld,
    output logic              out_pci,
    output logic [ADDR_W-1:0] out_addr
);
    import xlat_pkg::*;

    localparam int NUM_WIN = 1 << IDX_W;

    logic [NUM_WIN-1:0][ADDR_W-1:0] offs;
    region_e                        region;
    logic [IDX_W-1:0]               win_idx;
    logic [SEG_W-1:0]               seg_ofs;
    logic [ADDR_W-1:0]              pass_addr;

    xlat_win_regs #(
        .ADDR_W(ADDR_W), .SEG_W(SEG_W), .IDX_W(IDX_W), .RESET_BASE(RESET_BASE)
    ) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .offs(offs)
    );

    xlat_decode #(
        .ADDR_W(ADDR_W), .SEG_W(SEG_W), .IDX_W(IDX_W)
    ) u_dec (
        .addr(in_addr), .region(region), .win_idx(win_idx),
        .seg_ofs(seg_ofs), .pass_addr(pass_addr)
    );

    xlat_add_stage #(
        .ADDR_W(ADDR_W), .SEG_W(SEG_W), .IDX_W(IDX_W)
    ) u_add (
        .clk(clk), .rst(rst), .in_vld(in_vld), .region(region),
        .win_idx(win_idx), .seg_ofs(seg_ofs), .pass_addr(pass_addr),
        .offs(offs), .res_vld(out_vld), .res_pci(out_pci), .res_addr(out_addr)
    );

endmodule

// File: rtl/xlat_outbound_chk.sv
module xlat_outbound_chk #(
    parameter int  ADDR_W     = 32,
    parameter int  REGION_BIT = 27
) (
    input logic              clk,
    input logic              rst,
    input logic              in_vld,
    input logic [ADDR_W-1:0] in_addr,
    input logic              out_vld,
    input logic              out_pci,
    input logic [ADDR_W-1:0] out_addr
);
    localparam logic [ADDR_W-1:0] KEEP_MASK =
        ADDR_W'((64'd1 << (REGION_BIT + 1)) - 64'd1);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!out_vld && !out_pci && out_addr == '0));

    p_vld_follow_r2: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);

    p_vld_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> !out_vld);

    p_region_flag_r3: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> (out_pci == !$past(in_addr[REGION_BIT])));

    p_passthru_r5: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_addr[REGION_BIT]) |=> (out_addr == ($past(in_addr) & KEEP_MASK)));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> ($stable(out_addr) && $stable(out_pci)));

endmodule

bind xlat_outbound xlat_outbound_chk #(
    .ADDR_W(ADDR_W), .REGION_BIT(SEG_W + IDX_W)
) u_chk (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_addr(in_addr),
    .out_vld(out_vld), .out_pci(out_pci), .out_addr(out_addr)
);

// File: tb/tb_xlat_outbound.sv
module tb_xlat_outbound;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        in_vld = 1'b0;
    logic [31:0] in_addr = '0;
    logic        out_vld;
    logic        out_pci;
    logic [31:0] out_addr;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic [31:0] mdl_ofs [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    xlat_outbound dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .in_vld(in_vld), .in_addr(in_addr),
        .out_vld(out_vld), .out_pci(out_pci), .out_addr(out_addr)
    );

    function automatic logic [31:0] expect_addr(input logic [31:0] a);
        if (a[27]) return {4'h0, a[27:0]};
        return mdl_ofs[a[26:24]] + {8'h00, a[23:0]};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    // Present one request and sample the registered result one clock later.
    task automatic xlat(input logic [31:0] a, input string req);
        @(negedge clk);
        in_vld  = 1'b1;
        in_addr = a;
        @(posedge clk);
        #1;
        in_vld = 1'b0;
        check(req, "out_vld", 32'(out_vld), 32'd1);
        check(req, "out_pci", 32'(out_pci), 32'(!a[27]));
        check(req, "out_addr", out_addr, expect_addr(a));
    endtask

    task automatic wr_win(input logic [2:0] k, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = k; wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        mdl_ofs[k] = d;
    endtask

    task automatic t_reset();
        check("R1", "reset out_vld", 32'(out_vld), 32'd0);
        check("R1", "reset out_pci", 32'(out_pci), 32'd0);
        check("R1", "reset out_addr", out_addr, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R1", "post-reset out_vld", 32'(out_vld), 32'd0);
    endtask

    task automatic t_reset_windows();
        for (int k = 0; k < 8; k++) begin
            logic [31:0] a;
            a = {4'h0, 1'b0, 3'(k), 24'h00_1234};
            xlat(a, "R1");
            check("R1", "self-map", out_addr, {4'h1, a[27:0]});
        end
    endtask

    task automatic t_example();
        xlat(32'h1200_00FF, "R4");
        check("R4", "example", out_addr, 32'h1200_00FF);
        xlat(32'hF200_00FF, "R4");
        check("R4", "top nibble ignored", out_addr, 32'h1200_00FF);
    endtask

    task automatic t_nonpci();
        wr_win(3'd0, 32'hDEAD_0000);
        xlat(32'hA800_0010, "R5");
        check("R5", "pass-through", out_addr, 32'h0800_0010);
        xlat(32'h0FFF_FFFF, "R5");
        check("R5", "top of space", out_addr, 32'h0FFF_FFFF);
        check("R3", "flag other", 32'(out_pci), 32'd0);
    endtask

    task automatic t_write_use();
        wr_win(3'd5, 32'h4000_0000);
        xlat(32'h0512_3456, "R6");
        check("R6", "new offset", out_addr, 32'h4012_3456);
    endtask

    task automatic t_same_cycle();
        logic [31:0] old;
        old = mdl_ofs[3];
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd3; wr_data = 32'h7700_0000;
        in_vld = 1'b1; in_addr = 32'h0300_0042;
        @(posedge clk);
        #1;
        wr_en = 1'b0; in_vld = 1'b0;
        check("R6", "same-cycle old value", out_addr, old + 32'h42);
        mdl_ofs[3] = 32'h7700_0000;
        xlat(32'h0300_0042, "R6");
        check("R6", "next cycle new value", out_addr, 32'h7700_0042);
        // A write to window 6 alongside a request on window 1.
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd6; wr_data = 32'h0;
        in_vld = 1'b1; in_addr = 32'h0100_0001;
        @(posedge clk);
        #1;
        wr_en = 1'b0; in_vld = 1'b0;
        check("R7", "other window in same cycle", out_addr, mdl_ofs[1] + 32'h1);
        mdl_ofs[6] = 32'h0;
    endtask

    task automatic t_isolation();
        wr_win(3'd7, 32'h0000_0100);
        for (int k = 0; k < 8; k++) begin
            xlat({5'b0, 3'(k), 24'h000010}, "R7");
        end
    endtask

    task automatic t_wrap();
        wr_win(3'd4, 32'hFFFF_FF00);
        xlat(32'h0400_0200, "R8");
        check("R8", "wrap", out_addr, 32'h0000_0100);
    endtask

    task automatic t_hold();
        logic [31:0] last;
        xlat(32'h0200_0ABC, "R9");
        last = out_addr;
        @(negedge clk);
        in_addr = 32'h0800_0000;
        @(posedge clk);
        #1;
        check("R2", "vld drops", 32'(out_vld), 32'd0);
        check("R9", "addr held", out_addr, last);
        check("R9", "pci held", 32'(out_pci), 32'd1);
    endtask

    task automatic t_back_to_back();
        logic [31:0] seq [4];
        seq[0] = 32'h0000_0001; seq[1] = 32'h0900_0002;
        seq[2] = 32'h0700_0003; seq[3] = 32'h0E00_0004;
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            in_vld = 1'b1; in_addr = seq[i];
            @(posedge clk);
            #1;
            check("R2", "b2b vld", 32'(out_vld), 32'd1);
            check("R4", "b2b addr", out_addr, expect_addr(seq[i]));
            @(negedge clk);
        end
        in_vld = 1'b0;
    endtask

    initial begin
        for (int k = 0; k < 8; k++) mdl_ofs[k] = 32'h1000_0000 + (32'(k) << 24);
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        t_reset_windows();
        t_example();
        t_nonpci();
        t_write_use();
        t_same_cycle();
        t_isolation();
        t_wrap();
        t_hold();
        t_back_to_back();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL R2 watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule